// File: doc/BRIEF.md
# Multi-Channel Converter Scan Sequencer

This block runs scans of a successive-approximation converter with no processor help. A scan visits each enabled channel in ascending order. For each channel the block holds an acquisition window, then starts the converter and waits for its done pulse. A channel can optionally sample repeatedly and average the results in hardware. When the channel finishes, its result is written into that channel's result register. The converter, the input mux and the reference sit outside the block and are reached only through a start/done handshake.

A scan can be started in several ways. A firmware pulse starts one scan in any trigger mode. Continuous mode chains scans back to back. The hardware trigger input can act on its rising edge or on its level. A firmware or edge trigger that arrives while a scan is running raises a collision flag and is held until the running scan ends. Two sticky interrupt flags report end-of-scan and collision, and each is cleared by writing a one to it.

Top module: `adc_scan_seq`

## Requirements
- R1: Bit c of `chan_en` enables channel c. A scan converts the enabled channels in strictly ascending index order and drives the channel index on `conv_ch`. If no channel is enabled, no conversion takes place.
- R2: `acq_sel[2c+1:2c]` selects one of four acquisition slots for channel c. Slot s holds T = `acq_time[8s+7:8s]`. Each sample holds `conv_start` low for T cycles of acquisition, then raises it in the following cycle. The gap from the cycle in which `conv_done` is seen to the next `conv_start` is therefore T+1 cycles.
- R3: If `avg_en[c]` is set, channel c takes N = 2^(`avg_code`+1) samples back to back (2 to 256), and its result is the sum of those samples shifted right by `avg_code`+1. If `avg_en[c]` is clear, the channel takes one sample and stores it unchanged.
- R4: A one-cycle `fw_start` pulse starts one scan in every trigger mode. The block returns to idle after that scan.
- R5: In `trig_mode` 0 (firmware only), and in the spare code 3, `hw_trig` has no effect.
- R6: In `trig_mode` 1, each rising edge of `hw_trig` starts exactly one scan. Holding `hw_trig` high does not start another.
- R7: In `trig_mode` 2, scans run back to back while `hw_trig` is high. A scan that is already running when the level drops is completed.
- R8: While `cont_en` is high, scans run back to back, and `fw_start` and `hw_trig` are ignored without raising a collision. When `cont_en` drops, the running scan completes and the block goes idle.
- R9: A firmware or edge trigger that arrives while a scan runs sets `irq_coll`. Exactly one more scan then starts directly after the running one.
- R10: `irq_eos` is set when the last result of a scan is written. Both flags are sticky. A one on `irq_clr[0]` clears `irq_eos`, and a one on `irq_clr[1]` clears `irq_coll`, each on its own.
- R11: `busy` goes high in the cycle after a scan is accepted and goes low in the same cycle that the last result and `irq_eos` appear. `trig_mode` is taken only while the block is idle.
- R12: Channel c's result is held at `result[12c+11:12c]`. A scan leaves the result registers of disabled channels untouched. All results reset to zero.
- R13: `conv_start` is a one-cycle pulse. Only one conversion is outstanding at a time: no new start is issued until `conv_done` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | NCH | Per-channel enable |
| acq_sel | input | NCH*2 | Per-channel acquisition slot select |
| acq_time | input | 4*ATW | Four acquisition times in cycles |
| avg_en | input | NCH | Per-channel averaging enable |
| avg_code | input | 3 | Averaging count code, N = 2^(code+1) |
| trig_mode | input | 2 | 0 firmware only, 1 hardware edge, 2 hardware level |
| cont_en | input | 1 | Continuous scanning |
| fw_start | input | 1 | Firmware one-shot pulse |
| hw_trig | input | 1 | Hardware trigger |
| conv_start | output | 1 | Converter start pulse |
| conv_ch | output | log2(NCH) | Channel being converted |
| conv_done | input | 1 | Converter done pulse |
| conv_data | input | DW | Converter sample |
| result | output | NCH*DW | Per-channel result registers |
| busy | output | 1 | Scan in progress |
| irq_eos | output | 1 | Sticky end-of-scan flag |
| irq_coll | output | 1 | Sticky collision flag |
| irq_clr | input | 2 | Write-one-to-clear: bit 0 end-of-scan, bit 1 collision |

## Verification
The bench sweeps channel masks that include the lowest and highest channels alone, and it runs all eight averaging counts, including 256 samples of full-scale data. A wrong shift or a narrow accumulator would corrupt these results, and a skipped channel or a reordered visit would show in the logged channel sequence. Each acquisition gap is timed against the selected slot, so an off-by-one counter or a slot decoded from the wrong bits fails the gap check. The trigger tests look for three faults: a scan that repeats while an edge trigger is held high, a collision that is lost or that fires in continuous mode, and a level or continuous run that stops in the middle of a scan. A mode change made mid-scan must not act until the block is idle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ACQ  = 2'd1,
    SQ_CONV = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    TM_FW    = 2'd0,
    TM_EDGE  = 2'd1,
    TM_LEVEL = 2'd2,
    TM_SPARE = 2'd3
  } trig_mode_e;

endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] trig_mode,
  input  logic       cont_en,
  input  logic       fw_start,
  input  logic       hw_trig,
  input  logic       busy,
  input  logic       accept,
  output logic       scan_req,
  output logic       coll_evt
);

  trig_mode_e mode_q, mode_d;
  logic       hw_q;
  logic       pend_q, pend_d;
  logic       hw_rise, evt;

  // the mode is only taken over while no scan runs
  always_comb begin
    mode_d   = busy ? mode_q : trig_mode_e'(trig_mode);
    hw_rise  = hw_trig & ~hw_q;
    evt      = ~cont_en & (fw_start | ((mode_q == TM_EDGE) & hw_rise));
    coll_evt = evt & busy;
    // an idle event that coincides with an acceptance is the same scan
    pend_d   = (evt & (busy | ~accept)) | (pend_q & ~accept);
    scan_req = cont_en | pend_q | ((mode_q == TM_LEVEL) & hw_trig);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= TM_FW;
      hw_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      hw_q   <= hw_trig;
      pend_q <= pend_d;
    end
  end

  // R11: mode register frozen while a scan runs
  p_mode_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode_q));

  // R9: a collision leaves the trigger pending
  p_coll_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    coll_evt |=> pend_q);

  // R8: nothing collides in continuous mode
  p_cont_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cont_en |-> !coll_evt);

endmodule

// File: rtl/adc_seq_chan_pick.sv
module adc_seq_chan_pick #(
  parameter int NCH = 16,
  parameter int CHW = $clog2(NCH)
) (
  input  logic [NCH-1:0] mask,
  input  logic [CHW-1:0] cur,
  input  logic           from_start,
  output logic           found,
  output logic [CHW-1:0] idx
);

  // lowest enabled channel, either overall or above the current one
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask[i] && (from_start || (i > int'(cur)))) begin
        found = 1'b1;
        idx   = CHW'(i);
      end
    end
  end

endmodule

// File: rtl/adc_seq_avg.sv
module adc_seq_avg #(
  parameter int DW   = 12,
  parameter int CNTW = 8,
  parameter int LW   = $clog2(CNTW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_en,
  input  logic          avg_on,
  input  logic [LW-1:0] log2n,
  input  logic [DW-1:0] data,
  output logic          last_sample,
  output logic [DW-1:0] avg_res
);

  localparam int AW = DW + CNTW;

  logic [AW-1:0]   acc_q, acc_d, sum;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [CNTW:0]   target;

  always_comb begin
    target      = (CNTW + 1)'(1) << log2n;
    last_sample = ~avg_on | ({1'b0, cnt_q} == target - (CNTW + 1)'(1));
    sum         = acc_q + AW'(data);
    avg_res     = avg_on ? DW'(sum >> log2n) : data;
    acc_d       = acc_q;
    cnt_d       = cnt_q;
    if (sample_en) begin
      if (last_sample) begin
        acc_d = '0;
        cnt_d = '0;
      end else begin
        acc_d = sum;
        cnt_d = cnt_q + CNTW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  // R3: a finished channel leaves a clean accumulator for the next one
  p_acc_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && last_sample) |=> (acc_q == '0) && (cnt_q == '0));

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int NCH   = 16,
  parameter int DW    = 12,
  parameter int ATW   = 8,
  parameter int NSLOT = 4,
  parameter int AVGW  = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NCH-1:0]                    chan_en,
  input  logic [NCH*$clog2(NSLOT)-1:0]      acq_sel,
  input  logic [NSLOT*ATW-1:0]              acq_time,
  input  logic [NCH-1:0]                    avg_en,
  input  logic [AVGW-1:0]                   avg_code,
  input  logic [1:0]                        trig_mode,
  input  logic                              cont_en,
  input  logic                              fw_start,
  input  logic                              hw_trig,
  output logic                              conv_start,
  output logic [$clog2(NCH)-1:0]            conv_ch,
  input  logic                              conv_done,
  input  logic [DW-1:0]                     conv_data,
  output logic [NCH*DW-1:0]                 result,
  output logic                              busy,
  output logic                              irq_eos,
  output logic                              irq_coll,
  input  logic [1:0]                        irq_clr
);

  localparam int CHW  = $clog2(NCH);
  localparam int SW   = $clog2(NSLOT);
  localparam int CNTW = 2 ** AVGW;
  localparam int LW   = $clog2(CNTW + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  seq_state_e     state_q, state_d;
  logic [CHW-1:0] ch_q, ch_d, ld_ch;
  logic [ATW-1:0] acq_q, acq_d;
  logic [SW-1:0]  ld_slot;
  logic           eos_q, eos_d, coll_q, coll_d;
  logic [DW-1:0]  res_q [NCH];

  logic           first_ok, nxt_ok;
  logic [CHW-1:0] first_idx, nxt_idx;
  logic           scan_req, coll_evt, accept;
  logic           sample_en, last_sample, res_we, scan_end;
  logic [DW-1:0]  avg_res;
  logic [LW-1:0]  log2n;

  adc_seq_trig u_trig (
    .clk       (clk),
    .rst_n     (rst_ns),
    .trig_mode (trig_mode),
    .cont_en   (cont_en),
    .fw_start  (fw_start),
    .hw_trig   (hw_trig),
    .busy      (busy),
    .accept    (accept),
    .scan_req  (scan_req),
    .coll_evt  (coll_evt)
  );

  adc_seq_chan_pick #(.NCH(NCH), .CHW(CHW)) u_pick_first (
    .mask       (chan_en),
    .cur        (ch_q),
    .from_start (1'b1),
    .found      (first_ok),
    .idx        (first_idx)
  );

  adc_seq_chan_pick #(.NCH(NCH), .CHW(CHW)) u_pick_next (
    .mask       (chan_en),
    .cur        (ch_q),
    .from_start (1'b0),
    .found      (nxt_ok),
    .idx        (nxt_idx)
  );

  assign log2n = LW'(avg_code) + LW'(1);

  adc_seq_avg #(.DW(DW), .CNTW(CNTW), .LW(LW)) u_avg (
    .clk         (clk),
    .rst_n       (rst_ns),
    .sample_en   (sample_en),
    .avg_on      (avg_en[ch_q]),
    .log2n       (log2n),
    .data        (conv_data),
    .last_sample (last_sample),
    .avg_res     (avg_res)
  );

  always_comb begin
    busy       = (state_q != SQ_IDLE);
    conv_start = (state_q == SQ_ACQ) && (acq_q == '0);
    conv_ch    = ch_q;
    sample_en  = (state_q == SQ_CONV) && conv_done;
    res_we     = sample_en && last_sample;
    scan_end   = res_we && !nxt_ok;
    accept     = scan_req && first_ok && ((state_q == SQ_IDLE) || scan_end);
  end

  // channel whose acquisition time is loaded on the next entry into ACQ
  always_comb begin
    if ((state_q == SQ_CONV) && !last_sample) ld_ch = ch_q;
    else if ((state_q == SQ_CONV) && nxt_ok)  ld_ch = nxt_idx;
    else                                      ld_ch = first_idx;
    ld_slot = acq_sel[int'(ld_ch)*SW +: SW];
  end

  always_comb begin
    state_d = state_q;
    ch_d    = ch_q;
    acq_d   = acq_q;
    unique case (state_q)
      SQ_IDLE: begin
        if (accept) begin
          state_d = SQ_ACQ;
          ch_d    = first_idx;
          acq_d   = acq_time[int'(ld_slot)*ATW +: ATW];
        end
      end
      SQ_ACQ: begin
        if (acq_q == '0) state_d = SQ_CONV;
        else             acq_d   = acq_q - ATW'(1);
      end
      SQ_CONV: begin
        if (sample_en) begin
          if (!last_sample || nxt_ok || accept) begin
            state_d = SQ_ACQ;
            ch_d    = ld_ch;
            acq_d   = acq_time[int'(ld_slot)*ATW +: ATW];
          end else begin
            state_d = SQ_IDLE;
          end
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_comb begin
    eos_d  = scan_end | (eos_q & ~irq_clr[0]);
    coll_d = coll_evt | (coll_q & ~irq_clr[1]);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= SQ_IDLE;
      ch_q    <= '0;
      acq_q   <= '0;
      eos_q   <= 1'b0;
      coll_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
      acq_q   <= acq_d;
      eos_q   <= eos_d;
      coll_q  <= coll_d;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_res
    always_ff @(posedge clk or negedge rst_ns) begin
      if (!rst_ns)                          res_q[c] <= '0;
      else if (res_we && (ch_q == CHW'(c))) res_q[c] <= avg_res;
    end
    assign result[c*DW +: DW] = res_q[c];
  end

  assign irq_eos  = eos_q;
  assign irq_coll = coll_q;

  // R13: start is a single-cycle pulse
  p_start_pulse_r13: assert property (@(posedge clk) disable iff (!rst_ns)
    conv_start |=> !conv_start);

  // R13: no second start while a conversion is outstanding
  p_one_outstanding_r13: assert property (@(posedge clk) disable iff (!rst_ns)
    ((state_q == SQ_CONV) && !conv_done) |=> !conv_start);

  // R10: end of scan raises the flag
  p_eos_set_r10: assert property (@(posedge clk) disable iff (!rst_ns)
    scan_end |=> irq_eos);

  // R10: flag stays until cleared
  p_eos_sticky_r10: assert property (@(posedge clk) disable iff (!rst_ns)
    (irq_eos && !irq_clr[0]) |=> irq_eos);

  // R9: collision raises its flag
  p_coll_set_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    coll_evt |=> irq_coll);

  // R11: busy ends together with the end-of-scan flag
  p_busy_end_r11: assert property (@(posedge clk) disable iff (!rst_ns)
    $fell(busy) |-> irq_eos);

endmodule

// File: tb/adc_scan_seq_tb.sv
`timescale 1ns/1ps
module adc_scan_seq_tb;

  localparam int NCH = 16;
  localparam int DW  = 12;
  localparam int ATW = 8;
  localparam int CHW = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NCH-1:0]    chan_en;
  logic [NCH*2-1:0]  acq_sel;
  logic [4*ATW-1:0]  acq_time;
  logic [NCH-1:0]    avg_en;
  logic [2:0]        avg_code;
  logic [1:0]        trig_mode;
  logic              cont_en, fw_start, hw_trig;
  logic              conv_start;
  logic [CHW-1:0]    conv_ch;
  logic              conv_done;
  logic [DW-1:0]     conv_data;
  logic [NCH*DW-1:0] result;
  logic              busy, irq_eos, irq_coll;
  logic [1:0]        irq_clr;

  always #5 clk = ~clk;

  adc_scan_seq u_dut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .acq_sel(acq_sel),
    .acq_time(acq_time), .avg_en(avg_en), .avg_code(avg_code),
    .trig_mode(trig_mode), .cont_en(cont_en), .fw_start(fw_start),
    .hw_trig(hw_trig), .conv_start(conv_start), .conv_ch(conv_ch),
    .conv_done(conv_done), .conv_data(conv_data), .result(result),
    .busy(busy), .irq_eos(irq_eos), .irq_coll(irq_coll), .irq_clr(irq_clr)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nconv = 0;
  int ord_log [0:8191];
  int ord_n = 0;
  int lat = 0;
  int stub_ch = 0;
  int gseed = 1;
  bit all_max = 0;
  int done_cyc = 0;
  bit gap_ref = 0;
  bit busy_prev = 0;
  int sum_m [NCH];
  int cnt_m [NCH];
  logic [DW-1:0] exp_res [NCH];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int nsamp(input int c);
    return avg_en[c] ? (1 << (int'(avg_code) + 1)) : 1;
  endfunction

  function automatic int tacq(input int c);
    int s;
    s = int'(acq_sel[2*c +: 2]);
    return int'(acq_time[8*s +: 8]);
  endfunction

  function automatic int scan_len();
    int n;
    n = 0;
    for (int c = 0; c < NCH; c++) if (chan_en[c]) n += nsamp(c);
    return n;
  endfunction

  // converter stub and monitor, all on the falling edge
  always @(negedge clk) begin
    int d;
    cyc++;
    conv_done <= 1'b0;
    if (!busy) gap_ref = 0;
    if (busy_prev && !busy)
      chk(irq_eos == 1'b1, "R11 busy falls with eos", int'(irq_eos), 1);
    busy_prev = busy;
    if (lat > 0) begin
      lat--;
      if (lat == 0) begin
        gseed = (gseed * 75 + 74) % 65537;
        d = all_max ? 4095 : (gseed & 4095);
        conv_done <= 1'b1;
        conv_data <= DW'(d);
        done_cyc = cyc;
        gap_ref = 1;
        sum_m[stub_ch] += d;
        cnt_m[stub_ch]++;
        if (cnt_m[stub_ch] == nsamp(stub_ch)) begin
          exp_res[stub_ch] = DW'(sum_m[stub_ch] / nsamp(stub_ch));
          sum_m[stub_ch] = 0;
          cnt_m[stub_ch] = 0;
        end
      end
    end
    if (conv_start) begin
      if (gap_ref)
        chk(cyc - done_cyc == tacq(int'(conv_ch)) + 1, "R2 acquisition gap",
            cyc - done_cyc, tacq(int'(conv_ch)) + 1);
      chk(lat == 0, "R13 start with conversion outstanding", lat, 0);
      if (ord_n < 8192) ord_log[ord_n] = int'(conv_ch);
      ord_n++;
      nconv++;
      stub_ch = int'(conv_ch);
      lat = 2;
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic fw_pulse();
    @(posedge clk); #1 fw_start = 1'b1;
    @(posedge clk); #1 fw_start = 1'b0;
  endtask

  task automatic clr_irq(input logic [1:0] m);
    @(posedge clk); #1 irq_clr = m;
    @(posedge clk); #1 irq_clr = 2'b00;
  endtask

  task automatic wait_busy();
    for (int i = 0; i < 20 && !busy; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40000 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // one firmware scan with full order and result checks
  task automatic one_scan(input string tag);
    logic [NCH*DW-1:0] snap;
    int start, k;
    bit ok;
    snap  = result;
    start = ord_n;
    fw_pulse();
    wait_busy();
    wait_idle();
    k = start;
    ok = 1;
    for (int c = 0; c < NCH; c++)
      if (chan_en[c])
        for (int j = 0; j < nsamp(c); j++) begin
          if (ord_log[k] != c) ok = 0;
          k++;
        end
    chk(ok && (ord_n == k), {"R1 visit order ", tag}, ord_n - start, k - start);
    for (int c = 0; c < NCH; c++) begin
      if (chan_en[c])
        chk(result[c*DW +: DW] == exp_res[c], {"R3 result ", tag},
            int'(result[c*DW +: DW]), int'(exp_res[c]));
      else
        chk(result[c*DW +: DW] == snap[c*DW +: DW], {"R12 disabled kept ", tag},
            int'(result[c*DW +: DW]), int'(snap[c*DW +: DW]));
    end
    chk(irq_eos == 1'b1, {"R10 eos set ", tag}, int'(irq_eos), 1);
    clr_irq(2'b01);
    chk(irq_eos == 1'b0, {"R10 eos cleared ", tag}, int'(irq_eos), 0);
  endtask

  initial begin
    int base, len;
    logic [NCH-1:0] masks [6];
    masks[0] = 16'h0001; masks[1] = 16'h8000; masks[2] = 16'hA5C3;
    masks[3] = 16'hFFFF; masks[4] = 16'h0110; masks[5] = 16'h7FFE;
    for (int c = 0; c < NCH; c++) begin
      sum_m[c] = 0; cnt_m[c] = 0; exp_res[c] = '0;
    end
    rst_n = 1'b0;
    chan_en = '0; acq_sel = '0; acq_time = {8'd7, 8'd3, 8'd1, 8'd0};
    avg_en = '0; avg_code = 3'd0; trig_mode = 2'd0;
    cont_en = 0; fw_start = 0; hw_trig = 0; irq_clr = 2'b00;
    conv_done = 0; conv_data = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk(busy == 0 && conv_start == 0, "R11 reset idle", int'(busy), 0);
    chk(irq_eos == 0 && irq_coll == 0, "R10 reset flags", int'(irq_eos) + int'(irq_coll), 0);
    chk(result == '0, "R12 reset results", int'(result[DW-1:0]), 0);

    // R1 R2 R4 R12: mask sweep with rotating slot choice
    for (int it = 0; it < 6; it++) begin
      for (int c = 0; c < NCH; c++) acq_sel[2*c +: 2] = 2'((c + it) % 4);
      chan_en = masks[it];
      one_scan("mask sweep R4");
    end

    // R3: every averaging count, ch0 averaged, ch3 single
    chan_en = 16'h0009; avg_en = 16'h0001;
    for (int code = 0; code < 8; code++) begin
      avg_code = 3'(code);
      one_scan("avg sweep");
    end
    all_max = 1;
    one_scan("avg full scale");
    all_max = 0;
    avg_code = 3'd1; avg_en = 16'h0009;
    one_scan("avg two channels");

    // R5: hardware input ignored in firmware-only and spare modes
    avg_en = '0; chan_en = 16'h0006; len = scan_len();
    for (int m = 0; m < 4; m += 3) begin
      trig_mode = 2'(m);
      repeat (3) @(negedge clk);
      base = nconv;
      hw_trig = 1; repeat (4) @(negedge clk); hw_trig = 0;
      repeat (40) @(negedge clk);
      chk(nconv == base && busy == 0, "R5 hw ignored", nconv - base, 0);
    end

    // R6: held edge gives one scan; R4 firmware still works in edge mode
    trig_mode = 2'd1; repeat (3) @(negedge clk);
    base = nconv;
    hw_trig = 1; repeat (300) @(negedge clk); hw_trig = 0;
    wait_idle();
    chk(nconv - base == len, "R6 one scan per edge", nconv - base, len);
    base = nconv;
    fw_pulse(); wait_busy(); wait_idle();
    chk(nconv - base == len, "R4 fw in edge mode", nconv - base, len);

    // R7: level mode repeats and completes the running scan
    trig_mode = 2'd2; repeat (3) @(negedge clk);
    base = nconv;
    hw_trig = 1; repeat (150) @(negedge clk); hw_trig = 0;
    wait_idle();
    chk((nconv - base) % len == 0 && (nconv - base) >= 2 * len,
        "R7 level scans whole", nconv - base, len);
    chk(irq_coll == 0, "R7 level no collision", int'(irq_coll), 0);

    // R9: collision sets flag and adds exactly one scan
    trig_mode = 2'd0; repeat (3) @(negedge clk);
    clr_irq(2'b11);
    base = nconv;
    fw_pulse(); wait_busy(); repeat (3) @(negedge clk);
    fw_pulse();
    @(negedge clk);
    chk(irq_coll == 1, "R9 collision flag", int'(irq_coll), 1);
    wait_idle();
    chk(nconv - base == 2 * len, "R9 held trigger runs", nconv - base, 2 * len);
    clr_irq(2'b10);
    chk(irq_coll == 0 && irq_eos == 1, "R10 independent clear",
        int'(irq_coll) * 2 + int'(irq_eos), 1);
    clr_irq(2'b01);

    // R8: continuous ignores triggers and finishes the scan
    trig_mode = 2'd1; repeat (3) @(negedge clk);
    base = nconv;
    cont_en = 1;
    repeat (60) @(negedge clk);
    fw_pulse();
    hw_trig = 1; repeat (5) @(negedge clk); hw_trig = 0;
    repeat (60) @(negedge clk);
    chk(busy == 1, "R8 busy throughout", int'(busy), 1);
    cont_en = 0;
    wait_idle();
    chk(irq_coll == 0, "R8 no collision", int'(irq_coll), 0);
    chk((nconv - base) % len == 0 && (nconv - base) >= 2 * len,
        "R8 whole scans", nconv - base, len);
    repeat (30) @(negedge clk);
    chk(busy == 0, "R8 idle after stop", int'(busy), 0);

    // R11: mode change during a scan waits for idle
    trig_mode = 2'd0; repeat (3) @(negedge clk);
    base = nconv;
    fw_pulse(); wait_busy();
    trig_mode = 2'd1; hw_trig = 1;
    wait_idle();
    repeat (20) @(negedge clk);
    chk(nconv - base == len && irq_coll == 0, "R11 mode held while busy",
        nconv - base, len);
    hw_trig = 0;

    // R1: no enabled channel, no conversion
    chan_en = '0; repeat (3) @(negedge clk);
    base = nconv;
    fw_pulse(); repeat (30) @(negedge clk);
    chk(nconv == base && busy == 0, "R1 empty mask", nconv - base, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule